// File: doc/BRIEF.md
# Per-Core Private Interrupt Register Bank

This block holds the configuration and live state of the 32 private interrupt IDs that belong to one processor core. IDs 0 to 15 are software-generated; IDs 16 to 31 are driven by peripherals. Each ID has enable, pending and active flags, a group bit, a group-modifier bit, an 8-bit priority and a 2-bit trigger field. A wake-control register holds a sleep request that sends the core into a low-power state. The core leaves reset asleep.

Software reaches the bank through a request/response register channel. Each request carries a word index, a write flag, write data and a secure flag. Each request gets exactly one response, which carries read data and an error flag. A request is taken on a rising clock edge when `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is waiting, or when the waiting response is consumed in the same cycle. A response stays valid with constant data until `rsp_ready` is high, so a stalled consumer stops new requests from being taken.

Non-secure accesses see a shifted view of the priorities. The group-modifier and access-control registers are visible only to secure accesses. A one-cycle pulse on a peripheral input marks that peripheral's ID pending.

Top module: `pirq_bank`

## Requirements
- R1: After reset, every flag, group, modifier, access-control, trigger and priority bit is 0. The sleep request is 1 and `core_sleep` is high.
- R2: The enable, pending and active flags have a set word and a clear word: enable set at index 2 and clear at 3, pending set at 4 and clear at 5, active set at 6 and clear at 7. Writing 1 to bit n sets (set word) or clears (clear word) the flag of ID n, and writing 0 to a bit leaves that flag unchanged. Reading either word of a pair returns the current flags, with bit n holding ID n.
- R3: The priority words are at indices 16 to 23. Byte b (bits 8b+7:8b) of word 16+k is the priority of ID 4k+b. A secure write stores each byte unchanged, and a secure read returns the stored bytes.
- R4: On a non-secure read of a priority word, each byte is the stored priority shifted left by one, with the top bit dropped and bit 0 set to 0.
- R5: On a non-secure write of a priority word, each stored byte becomes 0x80 OR (written byte shifted right by one).
- R6: The trigger fields occupy two words: index 8 holds IDs 0 to 15 and index 9 holds IDs 16 to 31. Bits 2m+1:2m of each word belong to the m-th ID of that word. Both words can be read and written by any access.
- R7: The group word at index 1 holds one bit per ID (bit n is ID n). Secure and non-secure accesses can both read and write it.
- R8: The group-modifier word (index 10) and the access-control word (index 11) can be read and written by secure accesses only. A non-secure read of either word returns 0, and a non-secure write leaves it unchanged.
- R9: Bit 0 of the wake word (index 0) is the sleep request and drives `core_sleep`. Writing 0 wakes the core and writing 1 puts it to sleep. The other bits of the wake word read as 0.
- R10: Word indices 12 to 15 and 24 to 63 are invalid. Accessing one returns read data 0 with `rsp_err` set, and changes no state. Every valid index responds with `rsp_err` clear.
- R11: A pulse on bit k of `ppi_pulse` at an accepting clock edge, or at any other edge, sets the pending flag of ID 16+k. If a write to the clear-pending word with bit 16+k set is taken at the same edge, the flag ends up clear.
- R12: `rsp_valid` rises in the cycle after a request is taken. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_rdata` and `rsp_err` hold their values. A read returns the state that existed before the edge at which it was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Access is secure |
| req_addr | input | 6 | Word index of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Invalid word index |
| ppi_pulse | input | 16 | Peripheral pulses; bit k marks ID 16+k pending |
| core_sleep | output | 1 | Core held in low-power state |

## Verification
The flag words are driven with sparse patterns, with dense patterns and with all-zero words, so that write-one-to-act behaviour can be told apart from a plain store. The priority words are written and read under both security states, using bytes whose top or bottom bits are set, which exposes a missing or reversed shift. The secure-only words and invalid indices are hit with non-secure and bad accesses and then read back securely. This proves that nothing was stored. A peripheral pulse is driven both alone and in the same cycle as a pending clear, and a stalled response checks that the response data is held and that new requests are refused.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int DW        = 32;
  localparam int AW        = 6;
  localparam int NIRQ      = 32;
  localparam int NSGI      = 16;
  localparam int NPPI      = NIRQ - NSGI;
  localparam int PRIO_W    = 8;
  localparam int PPW       = DW / PRIO_W;
  localparam int PWORDS    = NIRQ / PPW;
  localparam int PSEL_W    = $clog2(PWORDS);
  localparam int TRIG_W    = 2;

  localparam logic [AW-1:0] IX_WAKE   = 6'd0;
  localparam logic [AW-1:0] IX_GRP    = 6'd1;
  localparam logic [AW-1:0] IX_EN_S   = 6'd2;
  localparam logic [AW-1:0] IX_EN_C   = 6'd3;
  localparam logic [AW-1:0] IX_PD_S   = 6'd4;
  localparam logic [AW-1:0] IX_PD_C   = 6'd5;
  localparam logic [AW-1:0] IX_AC_S   = 6'd6;
  localparam logic [AW-1:0] IX_AC_C   = 6'd7;
  localparam logic [AW-1:0] IX_TRG_LO = 6'd8;
  localparam logic [AW-1:0] IX_TRG_HI = 6'd9;
  localparam logic [AW-1:0] IX_GMOD   = 6'd10;
  localparam logic [AW-1:0] IX_NSAC   = 6'd11;
  localparam logic [AW-1:0] IX_PRIO   = 6'd16;

  typedef struct packed {
    logic valid;
    logic wake;
    logic grp;
    logic en_s;
    logic en_c;
    logic pd_s;
    logic pd_c;
    logic ac_s;
    logic ac_c;
    logic trg_lo;
    logic trg_hi;
    logic gmod;
    logic nsac;
    logic prio;
  } sel_t;
endpackage

// File: rtl/pirq_decode.sv
module pirq_decode
  import pirq_pkg::*;
(
  input  logic [AW-1:0] addr,
  output sel_t          sel
);
  always_comb begin
    sel        = '0;
    sel.wake   = (addr == IX_WAKE);
    sel.grp    = (addr == IX_GRP);
    sel.en_s   = (addr == IX_EN_S);
    sel.en_c   = (addr == IX_EN_C);
    sel.pd_s   = (addr == IX_PD_S);
    sel.pd_c   = (addr == IX_PD_C);
    sel.ac_s   = (addr == IX_AC_S);
    sel.ac_c   = (addr == IX_AC_C);
    sel.trg_lo = (addr == IX_TRG_LO);
    sel.trg_hi = (addr == IX_TRG_HI);
    sel.gmod   = (addr == IX_GMOD);
    sel.nsac   = (addr == IX_NSAC);
    sel.prio   = (addr >= IX_PRIO) && (addr < IX_PRIO + AW'(PWORDS));
    sel.valid  = sel.wake | sel.grp | sel.en_s | sel.en_c | sel.pd_s | sel.pd_c |
                 sel.ac_s | sel.ac_c | sel.trg_lo | sel.trg_hi | sel.gmod |
                 sel.nsac | sel.prio;
  end
endmodule

// File: rtl/pirq_flag_bank.sv
module pirq_flag_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wmask,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [W-1:0] set_m, clr_m;
  assign set_m = set_we ? wmask : '0;
  assign clr_m = clr_we ? wmask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q | set_m | hw_set) & ~clr_m;
  end

  // R2 / R11: a clear wins over every set source
  a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((q & $past(wmask)) == '0));
  // R2: set bits land, untouched bits hold
  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> ((q & $past(wmask)) == $past(wmask)));
  a_r2_zero_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we) |=> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/pirq_prio_bank.sv
module pirq_prio_bank
  import pirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              secure,
  input  logic [PSEL_W-1:0] word_sel,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);
  logic [NIRQ*PRIO_W-1:0] prio_flat;

  for (genvar g = 0; g < NIRQ; g++) begin : g_id
    localparam int WI = g / PPW;
    localparam int BI = g % PPW;
    logic [PRIO_W-1:0] wb, pq;
    assign wb = wdata[BI*PRIO_W +: PRIO_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pq <= '0;
      else if (we && word_sel == PSEL_W'(WI))
        pq <= secure ? wb : ({1'b1, {(PRIO_W-1){1'b0}}} | (wb >> 1));
    end
    assign prio_flat[g*PRIO_W +: PRIO_W] = pq;

    // R5: a non-secure write always leaves the top priority bit set
    a_r5_ns_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !secure && word_sel == PSEL_W'(WI)) |=> pq[PRIO_W-1]);
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < PPW; b++) begin
      logic [PRIO_W-1:0] p;
      p = prio_flat[(int'(word_sel) * PPW + b) * PRIO_W +: PRIO_W];
      rdata[b*PRIO_W +: PRIO_W] = secure ? p : {p[PRIO_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/pirq_bank.sv
module pirq_bank
  import pirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic            req_secure,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [DW-1:0]   rsp_rdata,
  output logic            rsp_err,
  input  logic [NPPI-1:0] ppi_pulse,
  output logic            core_sleep
);
  sel_t sel;
  logic acc, wr;
  logic [NIRQ-1:0] en_q, pd_q, ac_q, grp_q, gmod_q, nsac_q;
  logic [NIRQ*TRIG_W-1:0] trig_q;
  logic sleep_q;
  logic [DW-1:0] prio_rd, rd_mux;

  assign req_ready  = !rsp_valid || rsp_ready;
  assign acc        = req_valid && req_ready;
  assign wr         = acc && req_write;
  assign core_sleep = sleep_q;

  pirq_decode u_dec (.addr(req_addr), .sel(sel));

  pirq_flag_bank #(.W(NIRQ)) u_en (
    .clk(clk), .rst_n(rst_n), .set_we(wr && sel.en_s), .clr_we(wr && sel.en_c),
    .wmask(req_wdata), .hw_set('0), .q(en_q));
  pirq_flag_bank #(.W(NIRQ)) u_pd (
    .clk(clk), .rst_n(rst_n), .set_we(wr && sel.pd_s), .clr_we(wr && sel.pd_c),
    .wmask(req_wdata), .hw_set({ppi_pulse, {NSGI{1'b0}}}), .q(pd_q));
  pirq_flag_bank #(.W(NIRQ)) u_ac (
    .clk(clk), .rst_n(rst_n), .set_we(wr && sel.ac_s), .clr_we(wr && sel.ac_c),
    .wmask(req_wdata), .hw_set('0), .q(ac_q));

  pirq_prio_bank u_prio (
    .clk(clk), .rst_n(rst_n), .we(wr && sel.prio), .secure(req_secure),
    .word_sel(req_addr[PSEL_W-1:0]), .wdata(req_wdata), .rdata(prio_rd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q   <= '0;
      gmod_q  <= '0;
      nsac_q  <= '0;
      trig_q  <= '0;
      sleep_q <= 1'b1;
    end else if (wr) begin
      if (sel.grp)                 grp_q  <= req_wdata;
      if (sel.gmod && req_secure)  gmod_q <= req_wdata;
      if (sel.nsac && req_secure)  nsac_q <= req_wdata;
      if (sel.trg_lo)              trig_q[DW-1:0]  <= req_wdata;
      if (sel.trg_hi)              trig_q[2*DW-1:DW] <= req_wdata;
      if (sel.wake)                sleep_q <= req_wdata[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      sel.wake:            rd_mux = {{(DW-1){1'b0}}, sleep_q};
      sel.grp:             rd_mux = grp_q;
      sel.en_s, sel.en_c:  rd_mux = en_q;
      sel.pd_s, sel.pd_c:  rd_mux = pd_q;
      sel.ac_s, sel.ac_c:  rd_mux = ac_q;
      sel.trg_lo:          rd_mux = trig_q[DW-1:0];
      sel.trg_hi:          rd_mux = trig_q[2*DW-1:DW];
      sel.gmod:            rd_mux = req_secure ? gmod_q : '0;
      sel.nsac:            rd_mux = req_secure ? nsac_q : '0;
      sel.prio:            rd_mux = prio_rd;
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_mux;
      rsp_err   <= !sel.valid;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R12: a stalled response holds its contents
  a_r12_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));
  // R12: every accepted request yields a response next cycle
  a_r12_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
  // R10: an invalid index is flagged and leaves the core state alone
  a_r10_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !sel.valid) |=> (rsp_err && rsp_rdata == '0 && $stable(sleep_q) && $stable(grp_q)));
  // R8: non-secure writes do not reach the secure-only words
  a_r8_ns_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !req_secure && (sel.gmod || sel.nsac)) |=> ($stable(gmod_q) && $stable(nsac_q)));
  // R11: a peripheral pulse without a matching clear marks the ID pending
  a_r11_pulse_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (ppi_pulse[0] && !(wr && sel.pd_c && req_wdata[NSGI])) |=> pd_q[NSGI]);
endmodule

// File: tb/test_pirq_bank.sv
module test_pirq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic [15:0] ppi_pulse = '0;
  logic        req_ready, rsp_valid, rsp_err, core_sleep;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  logic [31:0] m_en, m_pd, m_ac, m_grp, m_gmod, m_nsac;
  logic [63:0] m_trig;
  byte unsigned m_prio [32];
  logic m_sleep;

  pirq_bank i_pirq_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_secure(req_secure), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .ppi_pulse(ppi_pulse),
    .core_sleep(core_sleep));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // sleep output compared against the model on every clock
  always @(negedge clk) if (rst_n && !done)
    chk(core_sleep == m_sleep, "R9", {31'b0, core_sleep}, {31'b0, m_sleep});

  function automatic logic [31:0] m_read(input bit s, input int a);
    logic [31:0] v = 0;
    case (a)
      0: v = {31'b0, m_sleep};
      1: v = m_grp;
      2, 3: v = m_en;
      4, 5: v = m_pd;
      6, 7: v = m_ac;
      8: v = m_trig[31:0];
      9: v = m_trig[63:32];
      10: v = s ? m_gmod : 0;
      11: v = s ? m_nsac : 0;
      default:
        if (a >= 16 && a < 24)
          for (int b = 0; b < 4; b++) begin
            int p = m_prio[(a-16)*4+b];
            v[b*8 +: 8] = s ? p[7:0] : 8'((p * 2) % 256);
          end
    endcase
    return v;
  endfunction

  function automatic bit m_valid(input int a);
    return (a < 12) || (a >= 16 && a < 24);
  endfunction

  task automatic m_apply(input bit w, input bit s, input int a, input logic [31:0] d, input logic [15:0] p);
    m_pd = m_pd | {p, 16'h0};
    if (w) case (a)
      0: m_sleep = d[0];
      1: m_grp = d;
      2: m_en = m_en | d;
      3: m_en = m_en & ~d;
      4: m_pd = m_pd | d;
      5: m_pd = m_pd & ~d;
      6: m_ac = m_ac | d;
      7: m_ac = m_ac & ~d;
      8: m_trig[31:0] = d;
      9: m_trig[63:32] = d;
      10: if (s) m_gmod = d;
      11: if (s) m_nsac = d;
      default:
        if (a >= 16 && a < 24)
          for (int b = 0; b < 4; b++) begin
            int x = int'(d[b*8 +: 8]);
            m_prio[(a-16)*4+b] = s ? byte'(x) : byte'(128 + x / 2);
          end
    endcase
  endtask

  task automatic op(input string req, input bit w, input bit s, input int a,
                    input logic [31:0] d, input logic [15:0] p = 16'h0);
    logic [31:0] exp;
    bit eerr;
    @(negedge clk);
    req_valid = 1; req_write = w; req_secure = s; req_addr = 6'(a); req_wdata = d; ppi_pulse = p;
    exp  = w ? 32'h0 : (m_valid(a) ? m_read(s, a) : 32'h0);
    eerr = !m_valid(a);
    @(posedge clk);
    #1 m_apply(w, s, a, d, p);
    @(negedge clk);
    req_valid = 0; ppi_pulse = '0;
    chk(rsp_valid == 1'b1, "R12", {31'b0, rsp_valid}, 32'h1);
    chk(rsp_rdata == exp, req, rsp_rdata, exp);
    chk(rsp_err == eerr, "R10", {31'b0, rsp_err}, {31'b0, eerr});
  endtask

  task automatic rd(input string req, input bit s, input int a);
    op(req, 1'b0, s, a, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      done = 1;
      $finish;
    end
  end

  initial begin
    m_en = 0; m_pd = 0; m_ac = 0; m_grp = 0; m_gmod = 0; m_nsac = 0; m_trig = 0; m_sleep = 1;
    foreach (m_prio[i]) m_prio[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state, R10 invalid indices among them
    for (int a = 0; a < 26; a++) rd("R1", 1'b1, a);
    chk(core_sleep == 1'b1, "R1", {31'b0, core_sleep}, 32'h1);

    // R2 set/clear words
    op("R2", 1, 0, 2, 32'h8000_00F1); rd("R2", 0, 2); rd("R2", 1, 3);
    op("R2", 1, 0, 3, 32'h0000_0011); rd("R2", 0, 2);
    op("R2", 1, 1, 2, 32'h0);          rd("R2", 0, 3);
    op("R2", 1, 1, 3, 32'h0);          rd("R2", 0, 2);
    op("R2", 1, 1, 4, 32'hFFFF_FFFF); op("R2", 1, 1, 5, 32'h5555_0000); rd("R2", 1, 4);
    op("R2", 1, 0, 6, 32'h0F0F_0F0F); op("R2", 1, 0, 7, 32'h0000_FFFF); rd("R2", 1, 7);

    // R3/R4/R5 priorities
    op("R3", 1, 1, 16, 32'h12FF_8001); rd("R3", 1, 16); rd("R4", 0, 16);
    op("R3", 1, 1, 23, 32'hA5C3_7E00); rd("R3", 1, 23);
    op("R5", 1, 0, 20, 32'h00FF_0180); rd("R5", 1, 20); rd("R4", 0, 20);
    op("R5", 1, 0, 17, 32'hFFFF_FFFF); rd("R5", 1, 17);

    // R6 triggers, R7 group
    op("R6", 1, 0, 8, 32'hC000_0003); op("R6", 1, 1, 9, 32'h2468_ACE1);
    rd("R6", 1, 8); rd("R6", 0, 9);
    op("R7", 1, 0, 1, 32'hDEAD_BEEF); rd("R7", 1, 1); rd("R7", 0, 1);

    // R8 secure-only words
    op("R8", 1, 1, 10, 32'h1234_5678); op("R8", 1, 1, 11, 32'h9ABC_DEF0);
    rd("R8", 0, 10); rd("R8", 0, 11);
    op("R8", 1, 0, 10, 32'hFFFF_FFFF); op("R8", 1, 0, 11, 32'h0);
    rd("R8", 1, 10); rd("R8", 1, 11);

    // R9 wake control
    op("R9", 1, 0, 0, 32'hFFFF_FFFE); rd("R9", 0, 0);
    op("R9", 1, 1, 0, 32'h0000_0001); rd("R9", 1, 0);
    op("R9", 1, 1, 0, 32'h0);

    // R10 invalid writes change nothing
    op("R10", 1, 1, 13, 32'hFFFF_FFFF); op("R10", 1, 1, 40, 32'hFFFF_FFFF);
    rd("R10", 1, 1); rd("R10", 1, 0); rd("R10", 1, 10); rd("R10", 1, 2);

    // R11 peripheral pulses
    op("R11", 1, 1, 5, 32'hFFFF_FFFF);
    op("R11", 0, 1, 4, 32'h0, 16'h8001); rd("R11", 1, 4);
    op("R11", 1, 1, 5, 32'h0001_0000, 16'h0003); rd("R11", 1, 4);
    op("R11", 1, 1, 5, 32'h0004_0000, 16'h0002); rd("R11", 1, 4);

    // R12 back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_write = 0; req_secure = 1; req_addr = 6'd1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 6'd1; req_wdata = 32'h0;
    for (int i = 0; i < 3; i++) begin
      chk(req_ready == 1'b0, "R12", {31'b0, req_ready}, 32'h0);
      chk(rsp_valid && rsp_rdata == m_grp, "R12", rsp_rdata, m_grp);
      @(negedge clk);
    end
    req_valid = 0; rsp_ready = 1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R12", {31'b0, rsp_valid}, 32'h0);
    rd("R12", 1, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule